// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A start pulse carries the first column, the access direction and the mode fields: a length code, an ordering select and a write-single select. From the next clock onward the block drives one column address per cycle, together with a beat-valid strobe and a final-beat flag. A controller drives the command and data pins from these outputs.

Each fixed-length burst stays inside a column block whose size is the burst length and whose base is a multiple of that length. The low column bits give the starting beat. In sequential order the low bits count upward and wrap inside the block. In interleaved order they are the starting low bits XOR the beat index. A page burst runs through the whole column space, wrapping at the top, until a terminate request ends it. When the write-single select is set, a write is one beat long and a read keeps the programmed length.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `beat_valid` and `last_beat` are 0.
- R2: When `start` is high at a clock edge, the cycle after that edge shows `beat_valid` = 1 and `col_out` equal to the `start_col` sampled at that edge.
- R3: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats on consecutive cycles. `last_beat` is 1 only on the final beat, and `beat_valid` is 1 whenever `last_beat` is 1.
- R4: With `mode_ilv` = 0 and a burst of length L, beat n has the low log2(L) bits equal to (start low bits + n) mod L.
- R5: With `mode_ilv` = 1 and a burst of length L, beat n has the low log2(L) bits equal to start low bits XOR n.
- R6: Every beat of a fixed-length burst keeps the column bits above log2(L) equal to those of `start_col`.
- R7: Length code 3'b111, which is used only with `mode_ilv` = 0, gives a page burst. Beat n is (`start_col` + n) mod 2^COL_W, and `last_beat` stays 0 until a terminate request is seen.
- R8: With `mode_wr_single` = 1, a start with `is_write` = 1 gives exactly one beat, with `last_beat` = 1. A start with `is_write` = 0 keeps the programmed length.
- R9: With `mode_wr_single` = 0, a write burst has the same length and order as a read burst.
- R10: If `term` is high at an edge while a beat that is not the final one is shown, the beat after that edge is the final one (`last_beat` = 1), and no beat follows it.
- R11: A `start` during a running burst abandons that burst. The next cycle shows the new `start_col` as beat 0 of the new sequence.
- R12: After a beat with `last_beat` = 1, and with no new `start`, `beat_valid` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst with the fields below |
| is_write | input | 1 | 1 for a write burst, 0 for a read burst |
| start_col | input | COL_W | First column of the burst |
| mode_len | input | 3 | Length code: 000=1, 001=2, 010=4, 011=8, 111=page |
| mode_ilv | input | 1 | 0 sequential order, 1 interleaved order |
| mode_wr_single | input | 1 | 1 makes write bursts a single beat |
| term | input | 1 | Terminate request for the running burst |
| col_out | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| last_beat | output | 1 | The current beat is the final one |

## Verification
The assertions assume that `start` is never given a reserved length code (100, 101, 110). They also assume that the page code never comes with interleaved order. These two conditions are checked as assertions on the inputs. The stimulus keeps within them: it sweeps only the four fixed codes with both orderings, and it uses the page code with sequential order only. Terminate and restart requests are raised only while a burst is running, and each is held for a single cycle.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  parameter int LOG_MAX = 3;
  localparam int LOG_W = $clog2(LOG_MAX + 1);

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef struct packed {
    logic [LOG_W-1:0] len_log;
    logic             full;
    logic             ilv;
  } burst_cfg_t;
endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_col_pkg::*;
(
  input  logic [2:0] len_code,
  input  logic       ilv,
  input  logic       wr_single,
  input  logic       is_write,
  output burst_cfg_t cfg
);
  always_comb begin
    cfg = '0;
    cfg.ilv = ilv;
    case (len_code)
      LEN_2:    cfg.len_log = LOG_W'(1);
      LEN_4:    cfg.len_log = LOG_W'(2);
      LEN_8:    cfg.len_log = LOG_W'(3);
      LEN_PAGE: cfg.full = 1'b1;
      default:  cfg.len_log = '0;
    endcase
    // single-location writes override any programmed length
    if (is_write && wr_single) begin
      cfg.len_log = '0;
      cfg.full    = 1'b0;
    end
  end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  burst_cfg_t       cfg,
  output logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] low;

  always_comb begin
    mask = cfg.full ? '1 : ((ONE << cfg.len_log) - ONE);
    low  = cfg.ilv ? (base ^ beat) : (base + beat);
    col  = (base & ~mask) | (low & mask);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_write,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       mode_len,
  input  logic             mode_ilv,
  input  logic             mode_wr_single,
  input  logic             term,
  output logic [COL_W-1:0] col_out,
  output logic             beat_valid,
  output logic             last_beat
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  burst_cfg_t       cfg_new, cfg_q, cfg_sel;
  logic [COL_W-1:0] base_q, cnt_q, cnt_nxt, last_idx;
  logic [COL_W-1:0] base_sel, beat_sel, col_nxt;
  logic             rst_d;

  burst_mode_dec u_dec (
    .len_code (mode_len),
    .ilv      (mode_ilv),
    .wr_single(mode_wr_single),
    .is_write (is_write),
    .cfg      (cfg_new)
  );

  always_comb begin
    cnt_nxt  = cnt_q + ONE;
    last_idx = (ONE << cfg_q.len_log) - ONE;
    base_sel = start ? start_col : base_q;
    beat_sel = start ? '0 : cnt_nxt;
    cfg_sel  = start ? cfg_new : cfg_q;
  end

  burst_addr_calc #(.COL_W(COL_W)) u_calc (
    .base(base_sel),
    .beat(beat_sel),
    .cfg (cfg_sel),
    .col (col_nxt)
  );

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      beat_valid <= 1'b0;
      last_beat  <= 1'b0;
      cnt_q      <= '0;
      base_q     <= '0;
      col_out    <= '0;
      cfg_q      <= '0;
    end else if (start) begin
      cfg_q      <= cfg_new;
      base_q     <= start_col;
      cnt_q      <= '0;
      col_out    <= col_nxt;
      beat_valid <= 1'b1;
      last_beat  <= !cfg_new.full && (cfg_new.len_log == '0);
    end else if (beat_valid && !last_beat) begin
      cnt_q      <= cnt_nxt;
      col_out    <= col_nxt;
      beat_valid <= 1'b1;
      last_beat  <= term || (!cfg_q.full && (cnt_nxt == last_idx));
    end else begin
      beat_valid <= 1'b0;
      last_beat  <= 1'b0;
    end
  end

  // R1: idle on the cycle following reset
  p_reset_idle_r1: assert property (@(posedge clk)
    rst_d |-> (!beat_valid && !last_beat));

  // R2: a start always yields a beat next cycle
  p_start_beat_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> beat_valid);

  // R3: the final-beat flag only accompanies a valid beat
  p_last_valid_r3: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> beat_valid);

  // R3: input code must not be reserved
  p_legal_code_r3: assert property (@(posedge clk) disable iff (rst)
    start |-> (mode_len inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111}));

  // R7: page length is used only with sequential order
  p_page_seq_r7: assert property (@(posedge clk) disable iff (rst)
    (start && mode_len == 3'b111) |-> !mode_ilv);

  // R7: a page burst does not finish on its own
  p_page_no_last_r7: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && cfg_q.full && !last_beat && !term && !start) |=> !last_beat);

  // R8: single-location write
  p_wr_single_r8: assert property (@(posedge clk) disable iff (rst)
    (start && is_write && mode_wr_single) |=> last_beat);

  // R10: terminate makes the following beat the final one
  p_term_last_r10: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !last_beat && term && !start) |=> (beat_valid && last_beat));

  // R11: restart shows the new starting column
  p_restart_col_r11: assert property (@(posedge clk) disable iff (rst)
    start |=> (col_out == $past(start_col)));

  // R12: nothing after the final beat without a new start
  p_idle_after_r12: assert property (@(posedge clk) disable iff (rst)
    (last_beat && !start) |=> !beat_valid);
endmodule

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  localparam int COL_W = 9;
  localparam int PAGE = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             is_write = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       mode_len = '0;
  logic             mode_ilv = 1'b0;
  logic             mode_wr_single = 1'b0;
  logic             term = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             beat_valid;
  logic             last_beat;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) i_burst_col_gen (
    .clk(clk), .rst(rst), .start(start), .is_write(is_write),
    .start_col(start_col), .mode_len(mode_len), .mode_ilv(mode_ilv),
    .mode_wr_single(mode_wr_single), .term(term),
    .col_out(col_out), .beat_valid(beat_valid), .last_beat(last_beat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_col(int base, int n, int lg, bit full, bit ilv);
    int len, blk, off;
    if (full) return (base + n) % PAGE;
    len = 1 << lg;
    blk = base - (base % len);
    off = base % len;
    if (ilv) return blk + (off ^ n);
    return blk + ((off + n) % len);
  endfunction

  // drives one burst and checks every beat and the idle cycle after it
  task automatic run_burst(input int code, input bit ilv, input int col,
                           input bit wr, input bit wrs, input int term_at,
                           input string tag);
    bit full;
    int lg, len, n;
    bit done;
    full = (code == 7) && !(wr && wrs);
    lg   = (wr && wrs) ? 0 : ((code == 7) ? 0 : code);
    len  = full ? 100000 : (1 << lg);
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(col); mode_len = 3'(code);
    mode_ilv = ilv; is_write = wr; mode_wr_single = wrs;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    done = 1'b0;
    while (!done && n < 700) begin
      bit exp_last;
      exp_last = (!full && n == len - 1) || (term_at >= 0 && n == term_at + 1);
      chk({tag, " valid"}, int'(beat_valid), 1);
      chk({tag, " col"}, int'(col_out), exp_col(col, n, lg, full, ilv));
      chk({tag, " last"}, int'(last_beat), int'(exp_last));
      if (!full) begin
        // R6: bits above the block size match the start column
        chk("R6 block", int'(col_out) >> lg, col >> lg);
      end
      if (exp_last) done = 1'b1;
      term = (n == term_at);
      @(negedge clk);
      term = 1'b0;
      n++;
    end
    chk("R12 idle", int'(beat_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(beat_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid", int'(beat_valid), 0);
    chk("R1 last", int'(last_beat), 0);

    // R3 R4 R5: every fixed length, both orders, every start column
    for (int code = 0; code < 4; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int c = 0; c < PAGE; c++)
          run_burst(code, ilv[0], c, 1'b0, 1'b0, -1, ilv ? "R5" : "R4");

    // R9: writes follow the programmed length when single-write is off
    for (int c = 0; c < 16; c++) begin
      run_burst(3, 1'b0, c * 7, 1'b1, 1'b0, -1, "R9");
      run_burst(2, 1'b1, c * 11, 1'b1, 1'b0, -1, "R9");
    end

    // R8: single-location writes, reads keep length
    for (int code = 0; code < 4; code++) begin
      run_burst(code, 1'b0, 37 + code, 1'b1, 1'b1, -1, "R8 write");
      run_burst(code, 1'b1, 37 + code, 1'b0, 1'b1, -1, "R8 read");
    end
    run_burst(7, 1'b0, 200, 1'b1, 1'b1, -1, "R8 page write");

    // R7: page burst wraps past the top column, ends only on terminate
    run_burst(7, 1'b0, 505, 1'b0, 1'b0, 12, "R7");
    run_burst(7, 1'b0, 0, 1'b0, 1'b0, 520, "R7");

    // R10: terminate inside fixed bursts
    run_burst(3, 1'b0, 13, 1'b0, 1'b0, 2, "R10");
    run_burst(3, 1'b1, 45, 1'b0, 1'b0, 0, "R10");
    run_burst(2, 1'b0, 6, 1'b1, 1'b0, 1, "R10");

    // R11: restart during a running burst
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(100); mode_len = 3'b011;
    mode_ilv = 1'b0; is_write = 1'b0; mode_wr_single = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 3; n++) begin
      chk("R11 first col", int'(col_out), exp_col(100, n, 3, 1'b0, 1'b0));
      @(negedge clk);
    end
    chk("R11 first col", int'(col_out), exp_col(100, 3, 3, 1'b0, 1'b0));
    start = 1'b1; start_col = COL_W'(301); mode_len = 3'b010; mode_ilv = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 4; n++) begin
      chk("R11 valid", int'(beat_valid), 1);
      chk("R11 col", int'(col_out), exp_col(301, n, 2, 1'b0, 1'b1));
      chk("R11 last", int'(last_beat), int'(n == 3));
      @(negedge clk);
    end
    chk("R12 idle after restart", int'(beat_valid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule